// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

The block turns a two's-complement vector (x, y) through a signed angle using only shifts and additions. It is fully unrolled. Each rotation step is a pipeline stage, so a new vector and angle can enter on every clock, and a rotated vector leaves a fixed number of cycles later. A valid flag travels with each sample.

Every stage uses a constant shift distance, equal to its index, and a constant arctangent increment. The shifted operand is plain wiring: the upper bits of the source go to the low positions, and the vacated top positions repeat the sign bit. A per-stage direction register holds the sign of the residual angle. That sign selects add or subtract on all three paths in the following stage.

The output carries the fixed CORDIC gain P = ∏ sqrt(1 + 2^-2i) over the stages, which is about 1.6468 for 16 stages. Callers who want unit gain pre-scale their inputs by 1/P.

Top module: `cordic_rotator`

## Requirements
- R1: A sample presented with `valid_i` high appears at the outputs with `valid_o` high exactly STAGES clock cycles later. With no sample in flight, `valid_o` stays low.
- R2: Every sample accepted on any cycle, back-to-back or with gaps, yields exactly one output in arrival order. No output appears without an input.
- R3: While `rst_ni` is low, `valid_o` is low, and asserting `rst_ni` clears it without waiting for a clock. Samples in flight at reset are discarded.
- R4: `z_i` is a signed two's-complement angle where 2^ANG_W is one full turn, so +2^(ANG_W-2) (0x4000 at 16 bits) is +90°. For |z_i| ≤ 2^(ANG_W-2) and P·|(x_i, y_i)| < 2^(DATA_W-1), `x_o` is within 24 LSB of P·(x_i·cos θ − y_i·sin θ).
- R5: Under the same conditions, `y_o` is within 24 LSB of P·(y_i·cos θ + x_i·sin θ).
- R6: Under the same conditions, the residual angle `z_o` has magnitude at most 4 LSB.
- R7: A zero angle returns the input vector scaled by P, within the R4 tolerance.
- R8: An angle of exactly ±2^(ANG_W-2) gives `x_o` ≈ ∓P·y_i and `y_o` ≈ ±P·x_i, within the R4 tolerance.
- R9: A zero input vector gives exactly zero on `x_o` and `y_o` for any angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| x_i | input | DATA_W | Input x, two's complement |
| y_i | input | DATA_W | Input y, two's complement |
| z_i | input | ANG_W | Rotation angle, full turn = 2^ANG_W |
| valid_o | output | 1 | Output sample valid |
| x_o | output | DATA_W | Rotated x, gain P |
| y_o | output | DATA_W | Rotated y, gain P |
| z_o | output | ANG_W | Residual angle |

## Verification
The residual-angle property assumes every valid angle lies within a quarter turn of zero. Outside that range the pipeline does not converge and `z_o` stays large. The stimulus draws angles only from [−0x4000, +0x4000] and includes both end points as directed cases. The stimulus also keeps each vector's radius small enough that P times the radius fits in DATA_W bits, so no intermediate stage wraps. The occupancy and early-output properties depend only on `valid_i`, and gaps in the input stream are used to test them.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // atan(2^-i) with a full turn = 2^32
  function automatic longint atan_q32(int i);
    case (i)
      0:  return 64'd536870912;
      1:  return 64'd316933406;
      2:  return 64'd167458907;
      3:  return 64'd85004756;
      4:  return 64'd42667331;
      5:  return 64'd21354465;
      6:  return 64'd10679838;
      7:  return 64'd5340245;
      8:  return 64'd2670163;
      9:  return 64'd1335087;
      10: return 64'd667544;
      11: return 64'd333772;
      12: return 64'd166886;
      13: return 64'd83443;
      14: return 64'd41722;
      15: return 64'd20861;
      default: return 64'd20861 >> (i - 15);
    endcase
  endfunction

  // rounded to an angle word of aw bits (aw <= 32)
  function automatic longint atan_ang(int i, int aw);
    longint c;
    c = atan_q32(i);
    if (aw >= 32) return c;
    return (c + (64'd1 << (31 - aw))) >> (32 - aw);
  endfunction

endpackage

// File: rtl/cordic_shift.sv
module cordic_shift #(
  parameter int W  = 16,
  parameter int SH = 0
) (
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] d_o
);
  // fixed wiring: upper W-SH bits routed low, top SH bits copy the sign
  generate
    if (SH == 0) begin : g_pass
      assign d_o = d_i;
    end else if (SH >= W) begin : g_sign
      assign d_o = {W{d_i[W-1]}};
    end else begin : g_wire
      assign d_o = {{SH{d_i[W-1]}}, d_i[W-1:SH]};
    end
  endgenerate
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int W   = 16,
  parameter int AW  = 16,
  parameter int IDX = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 neg_i,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  input  logic signed [AW-1:0] z_i,
  output logic                 valid_o,
  output logic                 neg_o,
  output logic signed [W-1:0]  x_o,
  output logic signed [W-1:0]  y_o,
  output logic signed [AW-1:0] z_o
);
  localparam logic signed [AW-1:0] ANG = AW'(cordic_pkg::atan_ang(IDX, AW));

  logic signed [W-1:0]  x_sh, y_sh, x_n, y_n;
  logic signed [AW-1:0] z_n;

  cordic_shift #(.W(W), .SH(IDX)) u_shx (.d_i(x_i), .d_o(x_sh));
  cordic_shift #(.W(W), .SH(IDX)) u_shy (.d_i(y_i), .d_o(y_sh));

  always_comb begin
    if (neg_i) begin
      x_n = x_i + y_sh;
      y_n = y_i - x_sh;
      z_n = z_i + ANG;
    end else begin
      x_n = x_i - y_sh;
      y_n = y_i + x_sh;
      z_n = z_i - ANG;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  // data path carries no reset
  always_ff @(posedge clk_i) begin
    x_o   <= x_n;
    y_o   <= y_n;
    z_o   <= z_n;
    neg_o <= z_n[AW-1];
  end
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int STAGES = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  input  logic signed [ANG_W-1:0]  z_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] x_o,
  output logic signed [DATA_W-1:0] y_o,
  output logic signed [ANG_W-1:0]  z_o
);
  logic                     v_s [STAGES+1];
  logic                     n_s [STAGES+1];
  logic signed [DATA_W-1:0] x_s [STAGES+1];
  logic signed [DATA_W-1:0] y_s [STAGES+1];
  logic signed [ANG_W-1:0]  z_s [STAGES+1];

  assign v_s[0] = valid_i;
  assign n_s[0] = z_i[ANG_W-1];
  assign x_s[0] = x_i;
  assign y_s[0] = y_i;
  assign z_s[0] = z_i;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      cordic_stage #(.W(DATA_W), .AW(ANG_W), .IDX(g)) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (v_s[g]),
        .neg_i   (n_s[g]),
        .x_i     (x_s[g]),
        .y_i     (y_s[g]),
        .z_i     (z_s[g]),
        .valid_o (v_s[g+1]),
        .neg_o   (n_s[g+1]),
        .x_o     (x_s[g+1]),
        .y_o     (y_s[g+1]),
        .z_o     (z_s[g+1])
      );
    end
  endgenerate

  assign valid_o = v_s[STAGES];
  assign x_o     = x_s[STAGES];
  assign y_o     = y_s[STAGES];
  assign z_o     = z_s[STAGES];
endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk #(
  parameter int STAGES = 16,
  parameter int ANG_W  = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic signed [ANG_W-1:0] z_o
);
  localparam int CW   = $clog2(STAGES + 2) + 1;
  localparam int ZTOL = 4;

  logic [CW-1:0] since_rst;
  logic [CW-1:0] in_flight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0;
      in_flight <= '0;
    end else begin
      if (since_rst < CW'(STAGES)) since_rst <= since_rst + 1'b1;
      in_flight <= in_flight + CW'(valid_i) - CW'(valid_o);
    end
  end

  // R3
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> !valid_o);

  // R1
  no_early_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < CW'(STAGES)) |-> !valid_o);

  // R2
  inflight_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_flight <= CW'(STAGES));

  // R2
  no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (in_flight != '0));

  // R6
  z_residual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (z_o <= ANG_W'(ZTOL) && z_o >= -ANG_W'(ZTOL)));
endmodule

bind cordic_rotator cordic_rotator_chk #(.STAGES(STAGES), .ANG_W(ANG_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .z_o     (z_o)
);

// File: tb/cordic_rotator_tb_top.sv
module cordic_rotator_tb_top;
  localparam int  W    = 16;
  localparam int  AW   = 16;
  localparam int  N    = 16;
  localparam real TOL  = 24.0;
  localparam int  ZTOL = 4;
  localparam real PI   = 3.14159265358979;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic valid_i;
  logic signed [W-1:0]  x_i, y_i, x_o, y_o;
  logic signed [AW-1:0] z_i, z_o;
  logic valid_o;

  always #5 clk_i = ~clk_i;

  cordic_rotator #(.DATA_W(W), .ANG_W(AW), .STAGES(N)) dut_i (
    .clk_i, .rst_ni, .valid_i, .x_i, .y_i, .z_i, .valid_o, .x_o, .y_o, .z_o
  );

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  real    gain;
  int     qx[$], qy[$], qz[$];
  longint qt[$];
  string  qtag[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(posedge clk_i) if (cyc > 100000) begin
    errors++;
    $display("FAIL R2 watchdog expired act=%0d exp<=100000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic sample();
    int x0, y0, z0;
    longint t0;
    string tag;
    real a, ex, ey;
    if (!valid_o) return;
    if (qx.size() == 0) begin
      chk(0, "R2", "output without input", 1, 0);
      return;
    end
    x0 = qx.pop_front(); y0 = qy.pop_front(); z0 = qz.pop_front();
    t0 = qt.pop_front(); tag = qtag.pop_front();
    a  = real'(z0) * 2.0 * PI / 65536.0;
    ex = gain * (real'(x0) * $cos(a) - real'(y0) * $sin(a));
    ey = gain * (real'(y0) * $cos(a) + real'(x0) * $sin(a));
    chk(cyc - t0 == N, "R1", "latency", cyc - t0, N);
    chk((real'(x_o) - ex) <= TOL && (ex - real'(x_o)) <= TOL,
        (tag == "") ? "R4" : tag, "x_o", x_o, longint'(ex));
    chk((real'(y_o) - ey) <= TOL && (ey - real'(y_o)) <= TOL,
        (tag == "") ? "R5" : tag, "y_o", y_o, longint'(ey));
    chk(int'(z_o) <= ZTOL && int'(z_o) >= -ZTOL, "R6", "z_o residual", z_o, 0);
    if (tag == "R9") begin
      chk(x_o == 0, "R9", "x_o zero vector", x_o, 0);
      chk(y_o == 0, "R9", "y_o zero vector", y_o, 0);
    end
  endtask

  task automatic step(bit v, int x, int y, int z, string tag);
    @(negedge clk_i);
    sample();
    valid_i = v;
    x_i = W'(x); y_i = W'(y); z_i = AW'(z);
    if (v) begin
      qx.push_back(x); qy.push_back(y); qz.push_back(z);
      qt.push_back(cyc); qtag.push_back(tag);
    end
  endtask

  task automatic rnd(bit v);
    int x, y, z;
    x = int'($urandom_range(26000)) - 13000;
    y = int'($urandom_range(26000)) - 13000;
    z = int'($urandom_range(32768)) - 16384;
    step(v, x, y, z, "");
  endtask

  task automatic flush();
    for (int i = 0; i < N + 3; i++) step(0, 0, 0, 0, "");
    chk(qx.size() == 0, "R2", "results outstanding", qx.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    gain = 1.0;
    for (int i = 0; i < N; i++) gain = gain * $sqrt(1.0 + 1.0 / real'(64'd1 << (2 * i)));
    rst_ni = 1'b0; valid_i = 1'b0; x_i = '0; y_i = '0; z_i = '0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R3", "valid_o in reset", valid_o, 0);
    rst_ni = 1'b1;

    // directed corners
    step(1, 12000, 0, 0, "R7");
    step(1, -9000, 7000, 0, "R7");
    step(1, 12000, 5000, 16384, "R8");
    step(1, 12000, 5000, -16384, "R8");
    step(1, 0, 0, 12345, "R9");
    step(1, 0, 0, -16384, "R9");
    step(1, -13000, -13000, 8192, "R4");
    step(1, 19000, 0, 8192, "R4");
    step(1, 0, -19000, -4000, "R5");
    flush();

    // back-to-back stream
    for (int i = 0; i < 60; i++) rnd(1);
    flush();

    // stream with gaps
    for (int i = 0; i < 200; i++) rnd($urandom_range(3) != 0);
    flush();

    // reset mid-stream drops in-flight samples
    for (int i = 0; i < N + 4; i++) rnd(1);
    #1 rst_ni = 1'b0;
    #1 chk(valid_o == 1'b0, "R3", "valid_o after async reset", valid_o, 0);
    qx.delete(); qy.delete(); qz.delete(); qt.delete(); qtag.delete();
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R3", "no output from flushed samples", valid_o, 0);
    end

    for (int i = 0; i < 100; i++) rnd(1);
    flush();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule